// File: doc/BRIEF.md
# Flash Write Status Reporter

This block builds the status byte that a flash device returns on host reads while an internal program or erase operation runs or is suspended. Host software polls it to learn when the operation has finished, so no separate ready/busy pin is needed. The command interpreter supplies the operation state, the byte being programmed, the mask of sectors chosen for erase, the current read address and a flag that says the erase command window has closed. The block tells the data-bus multiplexer when to use its status byte in place of array data.

Every status read is marked by a falling edge of the active-low output enable. Two toggle flip-flops advance on these edges. One advances on any status read while a program or erase is active. The other advances only when the read address falls inside a sector chosen for erase. A cycle limit catches operations that hang. When it trips, status stays on the bus until a reset command arrives.

Reads are single strobes, not a stream, so there is no valid/ready handshake. Every pin is a plain level or strobe, and the block never applies back-pressure.

Top module: `flash_wstat`

## Requirements
- R1: After reset, `stat_active` is 0 and `stat_byte` is 00h.
- R2: While `op_state` is 01 (program), `stat_active` is 1 and bit 7 of `stat_byte` is the inverse of bit 7 of `prog_data`.
- R3: While `op_state` is 10 (erase), `stat_active` is 1, bit 7 is 0 and bit 3 equals `erase_started`.
- R4: Bit 6 inverts once for each falling edge of `oe_n` seen while a program or erase is active, and only then. The new value is visible from the clock edge that detects the fall.
- R5: Bit 2 inverts once for each falling edge of `oe_n` during erase (10) or suspend (11) whose read address lies in a sector selected in `sector_sel`. The sector index is the top two address bits. Reads of other sectors leave bit 2 unchanged.
- R6: While `op_state` is 11 (erase suspended), a read of a selected sector gives `stat_active` 1 with bit 7 = 1 and bit 6 held. A read of an unselected sector gives `stat_active` 0, so array data is shown.
- R7: While `op_state` is 00 (idle) with no time-out, `stat_active` is 0 and `stat_byte` is 00h. Both toggle bits clear, so the first read of the next operation shows bit 6 = 1.
- R8: Once `LIMIT` clock cycles have been spent in program or erase, bit 5 becomes 1. From then on `stat_active` stays 1, even in idle, until `reset_cmd` is pulsed. That pulse clears bit 5 and the cycle count.
- R9: Bits 4, 1 and 0 of `stat_byte` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_state | input | 2 | 00 idle, 01 program, 10 erase, 11 erase suspended |
| prog_data | input | 8 | Byte being programmed |
| sector_sel | input | NSEC | Sectors chosen for erase |
| rd_addr | input | AW | Address of the current host read |
| erase_started | input | 1 | Erase command window has closed |
| oe_n | input | 1 | Active-low output enable; a falling edge marks a read |
| reset_cmd | input | 1 | One-cycle reset command, clears a time-out |
| stat_active | output | 1 | Status byte replaces array data |
| stat_byte | output | 8 | Status byte |

## Verification
On every clock cycle the assertions check three things. The first is how the polled bit 7 and the window bit 3 follow the operation state and the program byte. The second is that bit 6 stays still unless an output-enable fall was seen, and flips when one was. The third is that an unselected-sector read during suspend, or an idle state, gives up the bus unless a time-out holds it, and that a time-out persists until a reset command.

The exact alternation across long mixed read sequences can only be shown by the bench's scenarios. These cover the two toggles moving independently across sector-selected and unselected reads. They also cover toggles clearing between operations, the exact cycle at which the limit trips, and a low output enable that stays low and must not count as new reads.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;
  typedef enum logic [1:0] {
    OP_IDLE    = 2'b00,
    OP_PROGRAM = 2'b01,
    OP_ERASE   = 2'b10,
    OP_SUSPEND = 2'b11
  } op_e;

  localparam int BIT_POLL   = 7;
  localparam int BIT_TOG    = 6;
  localparam int BIT_LIMIT  = 5;
  localparam int BIT_WINDOW = 3;
  localparam int BIT_SECTOG = 2;

  function automatic logic op_busy(op_e s);
    return (s == OP_PROGRAM) || (s == OP_ERASE);
  endfunction
endpackage

// File: rtl/flash_wstat_strobe.sv
module flash_wstat_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_n,
  output logic rd_fall
);
  logic oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b1;
    else        oe_q <= oe_n;
  end

  assign rd_fall = oe_q & ~oe_n;
endmodule

// File: rtl/flash_wstat_tog.sv
module flash_wstat_tog (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (clear) q <= 1'b0;
    else if (step)  q <= ~q;
  end
endmodule

// File: rtl/flash_wstat_limit.sv
module flash_wstat_limit #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic idle,
  input  logic reset_cmd,
  output logic tmo
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else if (reset_cmd) begin
      cnt <= '0;
      tmo <= 1'b0;
    end else if (idle && !tmo) begin
      cnt <= '0;
    end else if (busy && !tmo) begin
      if (cnt == LAST) tmo <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/flash_wstat.sv
module flash_wstat #(
  parameter int AW    = 17,
  parameter int NSEC  = 4,
  parameter int LIMIT = 1000000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      op_state,
  input  logic [7:0]      prog_data,
  input  logic [NSEC-1:0] sector_sel,
  input  logic [AW-1:0]   rd_addr,
  input  logic            erase_started,
  input  logic            oe_n,
  input  logic            reset_cmd,
  output logic            stat_active,
  output logic [7:0]      stat_byte
);
  import flash_wstat_pkg::*;

  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1;

  op_e       op;
  op_e       eff;
  op_e       last_busy;
  logic      rd_fall;
  logic      tmo;
  logic      in_sel;
  logic      tog6;
  logic      tog2;
  logic      clr;
  logic [SW-1:0] sec_idx;

  assign op = op_e'(op_state);

  generate
    if (NSEC > 1) begin : g_multi
      assign sec_idx = rd_addr[AW-1 -: SW];
    end else begin : g_single
      assign sec_idx = '0;
    end
  endgenerate

  assign in_sel = sector_sel[sec_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           last_busy <= OP_PROGRAM;
    else if (op_busy(op)) last_busy <= op;
  end

  always_comb begin
    eff = op;
    if (op == OP_IDLE && tmo) eff = last_busy;
  end

  assign clr = (op == OP_IDLE) && !tmo;

  flash_wstat_strobe u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .oe_n    (oe_n),
    .rd_fall (rd_fall)
  );

  flash_wstat_limit #(.LIMIT(LIMIT)) u_limit (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (op_busy(op)),
    .idle      (op == OP_IDLE),
    .reset_cmd (reset_cmd),
    .tmo       (tmo)
  );

  flash_wstat_tog u_tog_op (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clr),
    .step  (rd_fall && op_busy(eff)),
    .q     (tog6)
  );

  flash_wstat_tog u_tog_sec (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clr),
    .step  (rd_fall && in_sel && (eff == OP_ERASE || eff == OP_SUSPEND)),
    .q     (tog2)
  );

  always_comb begin
    stat_active = tmo || op_busy(eff) || (eff == OP_SUSPEND && in_sel);
    stat_byte   = 8'h00;
    if (stat_active) begin
      stat_byte[BIT_POLL]   = (eff == OP_PROGRAM) ? ~prog_data[7] : (eff == OP_SUSPEND);
      stat_byte[BIT_TOG]    = tog6;
      stat_byte[BIT_LIMIT]  = tmo;
      stat_byte[BIT_WINDOW] = (eff == OP_ERASE) && erase_started;
      stat_byte[BIT_SECTOG] = tog2;
    end
  end
endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk #(
  parameter int AW   = 17,
  parameter int NSEC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      op_state,
  input logic [7:0]      prog_data,
  input logic [NSEC-1:0] sector_sel,
  input logic [AW-1:0]   rd_addr,
  input logic            erase_started,
  input logic            oe_n,
  input logic            reset_cmd,
  input logic            stat_active,
  input logic [7:0]      stat_byte
);
  localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1;

  logic oe_seen;
  logic fall_now;
  logic sel_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_seen <= 1'b1;
    else        oe_seen <= oe_n;
  end

  assign fall_now = oe_seen && !oe_n;
  assign sel_hit  = sector_sel[(NSEC > 1) ? rd_addr[AW-1 -: SW] : '0];

  assert_prog_poll_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_state == 2'b01 |-> stat_active && stat_byte[7] == ~prog_data[7]);

  assert_erase_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op_state == 2'b10 |-> stat_active && !stat_byte[7] && stat_byte[3] == erase_started);

  assert_tog_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_active && !fall_now) |=> (!stat_active || $stable(stat_byte[6])));

  assert_tog_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_state == 2'b01 || op_state == 2'b10) && fall_now)
      |=> (op_state != $past(op_state) || stat_byte[6] != $past(stat_byte[6])));

  assert_suspend_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 2'b11 && !sel_hit) |-> (!stat_active || stat_byte[5]));

  assert_idle_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_state == 2'b00 |-> (!stat_active || stat_byte[5]));

  assert_limit_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_byte[5] && !reset_cmd) |=> (stat_byte[5] && stat_active));

  assert_zero_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_byte[4] == 1'b0 && stat_byte[1:0] == 2'b00);
endmodule

bind flash_wstat flash_wstat_chk #(.AW(AW), .NSEC(NSEC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .op_state      (op_state),
  .prog_data     (prog_data),
  .sector_sel    (sector_sel),
  .rd_addr       (rd_addr),
  .erase_started (erase_started),
  .oe_n          (oe_n),
  .reset_cmd     (reset_cmd),
  .stat_active   (stat_active),
  .stat_byte     (stat_byte)
);

// File: tb/flash_wstat_test.sv
module flash_wstat_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 17;
  localparam int NSEC  = 4;
  localparam int LIMIT = 50;
  localparam int NV    = 14;

  // {op[19:18], d7[17], sel[16:13], sec[12:11], est[10], rd[9], act[8], byte[7:0]}
  localparam logic [19:0] VEC [NV] = '{
    {2'b00, 1'b0, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'b01, 1'b1, 4'b0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'h40},
    {2'b01, 1'b1, 4'b0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'h00},
    {2'b01, 1'b0, 4'b0000, 2'd0, 1'b0, 1'b1, 1'b1, 8'hC0},
    {2'b01, 1'b0, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b1, 8'hC0},
    {2'b00, 1'b0, 4'b0000, 2'd0, 1'b0, 1'b0, 1'b0, 8'h00},
    {2'b10, 1'b0, 4'b0001, 2'd0, 1'b0, 1'b1, 1'b1, 8'h44},
    {2'b10, 1'b0, 4'b0001, 2'd2, 1'b1, 1'b1, 1'b1, 8'h0C},
    {2'b10, 1'b0, 4'b0001, 2'd0, 1'b1, 1'b1, 1'b1, 8'h48},
    {2'b11, 1'b0, 4'b0001, 2'd0, 1'b1, 1'b1, 1'b1, 8'hC4},
    {2'b11, 1'b0, 4'b0001, 2'd1, 1'b1, 1'b1, 1'b0, 8'h00},
    {2'b11, 1'b0, 4'b0001, 2'd0, 1'b1, 1'b1, 1'b1, 8'hC0},
    {2'b10, 1'b0, 4'b0001, 2'd0, 1'b1, 1'b1, 1'b1, 8'h0C},
    {2'b00, 1'b0, 4'b0001, 2'd0, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      op_state = 2'b00;
  logic [7:0]      prog_data = 8'h00;
  logic [NSEC-1:0] sector_sel = '0;
  logic [AW-1:0]   rd_addr = '0;
  logic            erase_started = 1'b0;
  logic            oe_n = 1'b1;
  logic            reset_cmd = 1'b0;
  logic            stat_active;
  logic [7:0]      stat_byte;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wstat #(.AW(AW), .NSEC(NSEC), .LIMIT(LIMIT)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_state      (op_state),
    .prog_data     (prog_data),
    .sector_sel    (sector_sel),
    .rd_addr       (rd_addr),
    .erase_started (erase_started),
    .oe_n          (oe_n),
    .reset_cmd     (reset_cmd),
    .stat_active   (stat_active),
    .stat_byte     (stat_byte)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(2);
    check("R1 reset", {stat_active, stat_byte}, 9'h000);
    rst_n = 1'b1;
    step(1);

    // R2 R3 R4 R5 R6 R7 R9: vector walk
    for (int v = 0; v < NV; v++) begin
      op_state      = VEC[v][19:18];
      prog_data     = {VEC[v][17], 7'h15};
      sector_sel    = VEC[v][16:13];
      rd_addr       = {VEC[v][12:11], 15'h1234};
      erase_started = VEC[v][10];
      oe_n          = ~VEC[v][9];
      step(1);
      check($sformatf("R2/R3/R4/R5/R6/R7/R9 vector %0d", v),
            {stat_active, stat_byte}, VEC[v][8:0]);
      oe_n = 1'b1;
      step(1);
    end

    // R4: output enable held low counts as one read only
    op_state = 2'b01; prog_data = 8'h00;
    oe_n = 1'b0;
    step(1);
    check("R4 first fall", {stat_active, stat_byte}, 9'h1C0);
    step(3);
    check("R4 held low no toggle", {stat_active, stat_byte}, 9'h1C0);
    oe_n = 1'b1;
    step(1);
    oe_n = 1'b0;
    step(1);
    check("R4 second fall", {stat_active, stat_byte}, 9'h180);
    oe_n = 1'b1;
    op_state = 2'b00;
    step(2);
    check("R7 idle again", {stat_active, stat_byte}, 9'h000);

    // R8: time-out trips after LIMIT busy cycles
    op_state = 2'b01; prog_data = 8'h80;
    step(LIMIT - 1);
    check("R8 before limit", {stat_active, stat_byte[5]}, 2'b10);
    step(1);
    check("R8 at limit", {stat_active, stat_byte[5]}, 2'b11);
    op_state = 2'b00;
    step(3);
    check("R8 sticky in idle", {stat_active, stat_byte[5]}, 2'b11);
    reset_cmd = 1'b1;
    step(1);
    reset_cmd = 1'b0;
    check("R8 cleared by reset command", {stat_active, stat_byte}, 9'h000);
    step(1);
    op_state = 2'b10; sector_sel = 4'b0001; rd_addr = '0; erase_started = 1'b0;
    oe_n = 1'b0;
    step(1);
    check("R8 R7 fresh erase after clear", {stat_active, stat_byte}, 9'h144);
    oe_n = 1'b1;
    op_state = 2'b00;
    step(2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule